// File: doc/BRIEF.md
# Timestamp Playout Reassembly Buffer

This block sits at the receive end of a packetized constant-rate link. It takes framed packets, each a header word followed by payload words, and rebuilds the original word stream. Payload words go into a block-RAM store and a small descriptor queue remembers each complete packet. A packet at the head of the queue is held until a free-running local time counter shows that the configured playout delay has elapsed since the packet's timestamp.

When the packet number of a released packet skips ahead by a small amount, the missing packets are replaced with fill words. Each missing packet gets as many fill words as the last good packet had payload words, so the rebuilt stream keeps its length. Output words are paced by a credit counter. At the end of every window of `WIN` cycles, the number of payload words accepted during that window is added to the credit. Credit that is not spent stays for the next window, so the long-run output rate follows the input rate. The delay measured at each release is reported for monitoring. Packets that do not fit are dropped whole and counted.

Top module: `pr_playout`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `underflow`, `drop_cnt` and `meas_delay` are all zero, and the local time counter restarts from 0, advancing by one each cycle.
- R2: A word with `in_valid` and `in_sop` is a header. Bits [7:0] hold the payload length, bits [15:8] the packet number and bits [31:16] the timestamp. The following `in_valid` words, up to that length, are payload. Payload words leave on `out_data` in arrival order, and nothing else is changed.
- R3: The packet at the queue head is released only in a cycle where (local time − timestamp) mod 2^16 ≥ `cfg_delay`. The release cycle itself carries no output word. A word may leave on the next cycle.
- R4: On each release, `meas_delay` takes the value (local time − timestamp) mod 2^16 of that cycle, and the value is visible from the following cycle.
- R5: Let d be the released packet number minus the previous released number, mod 256. If d lies from 2 to `MAX_GAP`, then (d−1) × (previous payload length) words of value `FILL_WORD` are sent before the packet's payload. The first packet after reset never gets fill.
- R6: If d is 0, 1 or greater than `MAX_GAP`, no fill words are inserted.
- R7: A word leaves only in a cycle after one in which the credit was nonzero, and each word takes one credit. On the last cycle of every `WIN`-cycle window, the payload words accepted in that window (including that cycle) are added to the credit. Unused credit carries over.
- R8: Fill words take credit like payload words do. On release, the number of fill words scheduled is added to the credit.
- R9: A header is dropped with its payload, and `drop_cnt` rises by one, in three cases: its length is 0, the stored words plus its length would exceed `DEPTH`, or the descriptor queue already holds `DESC_DEPTH` packets.
- R10: `underflow` is high on the cycle after a cycle with nonzero credit in which no packet was being sent and none was released. While `underflow` is high, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delay | input | TS_W | Playout delay in cycles |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is a header |
| in_data | input | DATA_W | Header or payload word |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Rebuilt stream word |
| underflow | output | 1 | Credit available but nothing to send |
| meas_delay | output | TS_W | Delay measured at the latest release |
| drop_cnt | output | DROP_W | Packets dropped at input |

## Verification
A corrupted read pointer or payload counter shows up as a wrong `out_data` word on the very cycle it leaves. A wrong gap decision shows up as an extra or missing `FILL_WORD` run at the next packet boundary. A credit error shifts `out_valid` one window after the words were accepted, and because spare credit carries over, the shift persists in every later window. Wrong time-counter or timestamp arithmetic changes both the release cycle and `meas_delay` one cycle after release, and a wrong fill-level sum changes `drop_cnt` on the cycle after the offending header.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {IG_IDLE, IG_WRITE, IG_SKIP} ig_mode_t;
  typedef enum logic [1:0] {EG_IDLE, EG_FILL, EG_PAY} eg_mode_t;
endpackage

// File: rtl/pr_ram.sv
module pr_ram #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  // plain dual-port array with registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pr_desc_fifo.sv
module pr_desc_fifo #(
  parameter int TS_W  = 16,
  parameter int SEQ_W = 8,
  parameter int LEN_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TS_W-1:0]  push_ts,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [TS_W-1:0]  head_ts,
  output logic [SEQ_W-1:0] head_seq,
  output logic [LEN_W-1:0] head_len,
  output logic             empty,
  output logic             full
);
  localparam int AW  = $clog2(DEPTH);
  localparam int ENT = TS_W + SEQ_W + LEN_W;

  logic [ENT-1:0] store [DEPTH];
  logic [AW:0]    wp, rp;
  logic [ENT-1:0] head;

  assign empty = (wp == rp);
  assign full  = ((wp - rp) == (AW+1)'(DEPTH));
  assign head  = store[rp[AW-1:0]];
  assign {head_ts, head_seq, head_len} = head;

  always_ff @(posedge clk) begin
    if (push) store[wp[AW-1:0]] <= {push_ts, push_seq, push_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/pr_ingress.sv
module pr_ingress
  import pr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TS_W   = 16,
  parameter int SEQ_W  = 8,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 6,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W:0]   rptr,
  input  logic              desc_full,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W:0]   wptr,
  output logic              push,
  output logic [TS_W-1:0]   push_ts,
  output logic [SEQ_W-1:0]  push_seq,
  output logic [LEN_W-1:0]  push_len,
  output logic              word_acc,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int SEQ_LSB = LEN_W;
  localparam int TS_LSB  = LEN_W + SEQ_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SUM_W   = ((ADDR_W + 1 > LEN_W) ? ADDR_W + 1 : LEN_W) + 1;

  ig_mode_t         state;
  logic [LEN_W-1:0] rem;
  logic [TS_W-1:0]  ts_q;
  logic [SEQ_W-1:0] seq_q;
  logic [LEN_W-1:0] len_q;

  logic [TS_W-1:0]  h_ts;
  logic [SEQ_W-1:0] h_seq;
  logic [LEN_W-1:0] h_len;
  logic [ADDR_W:0]  used;
  logic [SUM_W-1:0] need;
  logic             fits;

  assign h_len = in_data[0 +: LEN_W];
  assign h_seq = in_data[SEQ_LSB +: SEQ_W];
  assign h_ts  = in_data[TS_LSB +: TS_W];
  assign used  = wptr - rptr;
  assign need  = SUM_W'(used) + SUM_W'(h_len);
  assign fits  = (need <= SUM_W'(DEPTH));

  assign word_acc = in_valid && !in_sop && (state == IG_WRITE);
  assign we       = word_acc;
  assign waddr    = wptr[ADDR_W-1:0];
  assign wdata    = in_data;
  // R2: descriptor becomes visible once the last payload word is stored
  assign push     = word_acc && (rem == LEN_W'(1));
  assign push_ts  = ts_q;
  assign push_seq = seq_q;
  assign push_len = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IG_IDLE;
      wptr     <= '0;
      rem      <= '0;
      ts_q     <= '0;
      seq_q    <= '0;
      len_q    <= '0;
      drop_cnt <= '0;
    end else if (in_valid && in_sop) begin
      // R9: whole-packet admission decided at the header
      if (h_len == '0 || !fits || desc_full) begin
        state    <= IG_SKIP;
        drop_cnt <= drop_cnt + 1'b1;
      end else begin
        state <= IG_WRITE;
        rem   <= h_len;
        ts_q  <= h_ts;
        seq_q <= h_seq;
        len_q <= h_len;
      end
    end else if (word_acc) begin
      wptr <= wptr + 1'b1;
      rem  <= rem - 1'b1;
      if (rem == LEN_W'(1)) state <= IG_IDLE;
    end
  end
endmodule

// File: rtl/pr_pacer.sv
module pr_pacer #(
  parameter int WIN      = 16,
  parameter int CREDIT_W = 16,
  parameter int FILL_W   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_in,
  input  logic                emit,
  input  logic [FILL_W-1:0]   gap_add,
  output logic [CREDIT_W-1:0] credit,
  output logic                credit_ok
);
  localparam int WIN_W = (WIN > 2) ? $clog2(WIN) : 1;
  localparam int ACC_W = $clog2(WIN + 1);

  logic [WIN_W-1:0]    wcnt;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    acc_now;
  logic                win_end;
  logic [CREDIT_W-1:0] gain;

  assign win_end   = (wcnt == WIN_W'(WIN - 1));
  assign acc_now   = acc + ACC_W'(word_in);
  assign gain      = win_end ? CREDIT_W'(acc_now) : '0;
  assign credit_ok = (credit != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      acc    <= '0;
      credit <= '0;
    end else begin
      wcnt <= win_end ? '0 : wcnt + 1'b1;
      acc  <= win_end ? '0 : acc_now;
      // R7 window refill with carry, R8 fill words granted at release
      credit <= credit + gain + CREDIT_W'(gap_add) - CREDIT_W'(emit);
    end
  end
endmodule

// File: rtl/pr_egress.sv
module pr_egress
  import pr_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int SEQ_W   = 8,
  parameter int LEN_W   = 8,
  parameter int ADDR_W  = 6,
  parameter int MAX_GAP = 4,
  parameter int FILL_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   cfg_delay,
  input  logic [TS_W-1:0]   now,
  input  logic              d_empty,
  input  logic [TS_W-1:0]   d_ts,
  input  logic [SEQ_W-1:0]  d_seq,
  input  logic [LEN_W-1:0]  d_len,
  input  logic              credit_ok,
  output logic              load,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rptr,
  output logic              sel_fill,
  output logic              out_valid,
  output logic [TS_W-1:0]   meas_delay,
  output logic              underflow,
  output logic [FILL_W-1:0] gap_add,
  output logic              emit
);
  eg_mode_t          mode;
  logic [FILL_W-1:0] fill_left;
  logic [LEN_W-1:0]  pay_left;
  logic              have_last;
  logic [SEQ_W-1:0]  last_seq;
  logic [LEN_W-1:0]  last_len;

  logic [TS_W-1:0]   elapsed;
  logic [SEQ_W-1:0]  diff;
  logic              gap;
  logic [FILL_W-1:0] fill_calc;

  // R3: modular age of the head packet
  assign elapsed = now - d_ts;
  assign load    = (mode == EG_IDLE) && !d_empty && (elapsed >= cfg_delay);
  // R5, R6: only a short forward jump is treated as loss
  assign diff    = d_seq - last_seq;
  assign gap     = have_last && (diff >= SEQ_W'(2)) && (diff <= SEQ_W'(MAX_GAP));
  assign fill_calc = gap ? FILL_W'(diff - 1'b1) * FILL_W'(last_len) : '0;
  assign gap_add = load ? fill_calc : '0;
  assign emit    = (mode != EG_IDLE) && credit_ok;
  assign re      = emit && (mode == EG_PAY);
  assign raddr   = rptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= EG_IDLE;
      fill_left  <= '0;
      pay_left   <= '0;
      have_last  <= 1'b0;
      last_seq   <= '0;
      last_len   <= '0;
      rptr       <= '0;
      sel_fill   <= 1'b0;
      out_valid  <= 1'b0;
      meas_delay <= '0;
      underflow  <= 1'b0;
    end else begin
      out_valid <= emit;
      sel_fill  <= (mode == EG_FILL);
      underflow <= credit_ok && (mode == EG_IDLE) && !load;
      case (mode)
        EG_IDLE: if (load) begin
          meas_delay <= elapsed;
          have_last  <= 1'b1;
          last_seq   <= d_seq;
          last_len   <= d_len;
          pay_left   <= d_len;
          fill_left  <= fill_calc;
          mode       <= (fill_calc != '0) ? EG_FILL : EG_PAY;
        end
        EG_FILL: if (emit) begin
          fill_left <= fill_left - 1'b1;
          if (fill_left == FILL_W'(1)) mode <= EG_PAY;
        end
        EG_PAY: if (emit) begin
          rptr     <= rptr + 1'b1;
          pay_left <= pay_left - 1'b1;
          if (pay_left == LEN_W'(1)) mode <= EG_IDLE;
        end
        default: mode <= EG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pr_playout.sv
module pr_playout #(
  parameter int          DATA_W     = 32,
  parameter int          TS_W       = 16,
  parameter int          SEQ_W      = 8,
  parameter int          LEN_W      = 8,
  parameter int          DEPTH      = 64,
  parameter int          DESC_DEPTH = 8,
  parameter int          WIN        = 16,
  parameter int          MAX_GAP    = 4,
  parameter int          CREDIT_W   = 16,
  parameter int          DROP_W     = 16,
  parameter logic [31:0] FILL_WORD  = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   cfg_delay,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              underflow,
  output logic [TS_W-1:0]   meas_delay,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int FILL_W = $clog2(MAX_GAP * (1 << LEN_W));

  logic [TS_W-1:0]     now;
  logic                we, re, push, word_acc, desc_full, desc_empty;
  logic [ADDR_W-1:0]   waddr, raddr;
  logic [DATA_W-1:0]   wdata, ram_q;
  logic [ADDR_W:0]     wptr, rptr, fifo_count;
  logic [TS_W-1:0]     push_ts, head_ts;
  logic [SEQ_W-1:0]    push_seq, head_seq;
  logic [LEN_W-1:0]    push_len, head_len;
  logic                eg_load, sel_fill, emit, credit_ok;
  logic [FILL_W-1:0]   gap_add;
  logic [CREDIT_W-1:0] credit;

  // R1, R3: local time base
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  assign fifo_count = wptr - rptr;
  assign out_data   = sel_fill ? DATA_W'(FILL_WORD) : ram_q;

  pr_ingress #(.DATA_W(DATA_W), .TS_W(TS_W), .SEQ_W(SEQ_W), .LEN_W(LEN_W),
               .ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .rptr(rptr), .desc_full(desc_full), .we(we), .waddr(waddr), .wdata(wdata),
    .wptr(wptr), .push(push), .push_ts(push_ts), .push_seq(push_seq),
    .push_len(push_len), .word_acc(word_acc), .drop_cnt(drop_cnt)
  );

  pr_ram #(.W(DATA_W), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(ram_q)
  );

  pr_desc_fifo #(.TS_W(TS_W), .SEQ_W(SEQ_W), .LEN_W(LEN_W), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst(rst), .push(push), .push_ts(push_ts), .push_seq(push_seq),
    .push_len(push_len), .pop(eg_load), .head_ts(head_ts), .head_seq(head_seq),
    .head_len(head_len), .empty(desc_empty), .full(desc_full)
  );

  pr_egress #(.TS_W(TS_W), .SEQ_W(SEQ_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
              .MAX_GAP(MAX_GAP), .FILL_W(FILL_W)) u_out (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .now(now), .d_empty(desc_empty),
    .d_ts(head_ts), .d_seq(head_seq), .d_len(head_len), .credit_ok(credit_ok),
    .load(eg_load), .re(re), .raddr(raddr), .rptr(rptr), .sel_fill(sel_fill),
    .out_valid(out_valid), .meas_delay(meas_delay), .underflow(underflow),
    .gap_add(gap_add), .emit(emit)
  );

  pr_pacer #(.WIN(WIN), .CREDIT_W(CREDIT_W), .FILL_W(FILL_W)) u_pace (
    .clk(clk), .rst(rst), .word_in(word_acc), .emit(emit), .gap_add(gap_add),
    .credit(credit), .credit_ok(credit_ok)
  );
endmodule

// File: rtl/pr_playout_chk.sv
module pr_playout_chk #(
  parameter int TS_W     = 16,
  parameter int ADDR_W   = 6,
  parameter int CREDIT_W = 16,
  parameter int DROP_W   = 16,
  parameter int DEPTH    = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                out_valid,
  input logic                underflow,
  input logic [DROP_W-1:0]   drop_cnt,
  input logic [TS_W-1:0]     meas_delay,
  input logic [TS_W-1:0]     cfg_delay,
  input logic                load,
  input logic [CREDIT_W-1:0] credit,
  input logic [ADDR_W:0]     fifo_count
);
  a_r7_word_needs_credit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(credit) != '0));

  a_r9_drop_single_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_cnt) |-> (drop_cnt == $past(drop_cnt) + 1'b1));

  a_r9_store_bounded: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= (ADDR_W+1)'(DEPTH));

  a_r4_delay_met: assert property (@(posedge clk) disable iff (rst)
    load |=> (meas_delay >= $past(cfg_delay)));

  a_r10_underflow_quiet: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !out_valid);
endmodule

bind pr_playout pr_playout_chk #(
  .TS_W(TS_W), .ADDR_W(ADDR_W), .CREDIT_W(CREDIT_W), .DROP_W(DROP_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .underflow(underflow),
  .drop_cnt(drop_cnt), .meas_delay(meas_delay), .cfg_delay(cfg_delay),
  .load(eg_load), .credit(credit), .fifo_count(fifo_count)
);

// File: tb/pr_playout_test.sv
module pr_playout_test;
  localparam logic [31:0] FILLW = 32'hDEAD_BEEF;
  localparam int WIN = 16;
  localparam int MAXG = 4;
  localparam int DEPTH = 64;
  localparam int DDEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cfg_delay = 16'd30;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic out_valid, underflow;
  logic [31:0] out_data;
  logic [15:0] meas_delay, drop_cnt;

  int total = 0, bad = 0, cyc = 0;
  int fill_seen = 0, pay_seen = 0, under_seen = 0;

  always #10 clk = ~clk;

  pr_playout uut (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .underflow(underflow), .meas_delay(meas_delay), .drop_cnt(drop_cnt)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] mq[$];
  logic [15:0] dts[$];
  logic [7:0]  dseq[$], dlen[$];
  int m_wstate, m_rem, m_mode, m_fill, m_pay, m_have, m_credit, m_wcnt, m_acc, m_drop;
  logic [15:0] m_now, m_meas, m_hts, m_el;
  logic [7:0]  m_hseq, m_hlen, m_lseq, m_llen, m_diff;
  logic [31:0] m_data;
  logic m_valid, m_under;
  int msz, dsz, inw, emit, ld, gadd, wend;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); dts.delete(); dseq.delete(); dlen.delete();
      m_wstate = 0; m_rem = 0; m_mode = 0; m_fill = 0; m_pay = 0; m_have = 0;
      m_credit = 0; m_wcnt = 0; m_acc = 0; m_drop = 0; m_now = 0; m_meas = 0;
      m_lseq = 0; m_llen = 0; m_valid = 0; m_under = 0; m_data = 0;
    end else begin
      msz = mq.size(); dsz = dts.size();
      inw = (in_valid && !in_sop && m_wstate == 1) ? 1 : 0;
      emit = (m_mode != 0 && m_credit > 0) ? 1 : 0;
      ld = 0; gadd = 0;
      m_el = (dsz > 0) ? m_now - dts[0] : 16'd0;
      if (m_mode == 0 && dsz > 0 && m_el >= cfg_delay) ld = 1;
      m_under = (m_credit > 0 && m_mode == 0 && ld == 0);
      m_valid = (emit == 1);
      if (ld == 1) begin
        m_diff = dseq[0] - m_lseq;
        if (m_have == 1 && m_diff >= 2 && m_diff <= MAXG) gadd = (int'(m_diff) - 1) * int'(m_llen);
        m_meas = m_el; m_have = 1; m_lseq = dseq[0]; m_llen = dlen[0];
        m_pay = dlen[0]; m_fill = gadd; m_mode = (gadd > 0) ? 1 : 2;
        void'(dts.pop_front()); void'(dseq.pop_front()); void'(dlen.pop_front());
      end else if (emit == 1 && m_mode == 1) begin
        m_data = FILLW; m_fill--;
        if (m_fill == 0) m_mode = 2;
      end else if (emit == 1 && m_mode == 2) begin
        m_data = mq.pop_front(); m_pay--;
        if (m_pay == 0) m_mode = 0;
      end
      wend = (m_wcnt == WIN - 1) ? 1 : 0;
      m_credit = m_credit - emit + gadd + (wend == 1 ? m_acc + inw : 0);  // R7, R8
      m_acc = (wend == 1) ? 0 : m_acc + inw;
      m_wcnt = (wend == 1) ? 0 : m_wcnt + 1;
      if (in_valid && in_sop) begin
        m_hts = in_data[31:16]; m_hseq = in_data[15:8]; m_hlen = in_data[7:0];
        if (m_hlen == 0 || msz + int'(m_hlen) > DEPTH || dsz == DDEPTH) begin
          m_drop++; m_wstate = 2;
        end else begin
          m_wstate = 1; m_rem = m_hlen;
        end
      end else if (inw == 1) begin
        mq.push_back(in_data); m_rem--;
        if (m_rem == 0) begin
          dts.push_back(m_hts); dseq.push_back(m_hseq); dlen.push_back(m_hlen); m_wstate = 0;
        end
      end
      m_now = m_now + 1'b1;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (out_valid !== m_valid) begin
        bad++; $display("FAIL R3,R7 out_valid actual=%0b expected=%0b t=%0d", out_valid, m_valid, cyc);
      end
      if (m_valid) begin
        total++;
        if (out_data !== m_data) begin
          bad++; $display("FAIL R2,R5 out_data actual=%h expected=%h t=%0d", out_data, m_data, cyc);
        end
      end
      total++;
      if (underflow !== m_under) begin
        bad++; $display("FAIL R10 underflow actual=%0b expected=%0b t=%0d", underflow, m_under, cyc);
      end
      total++;
      if (meas_delay !== m_meas) begin
        bad++; $display("FAIL R4 meas_delay actual=%0d expected=%0d t=%0d", meas_delay, m_meas, cyc);
      end
      total++;
      if (drop_cnt !== 16'(m_drop)) begin
        bad++; $display("FAIL R9 drop_cnt actual=%0d expected=%0d t=%0d", drop_cnt, m_drop, cyc);
      end
      if (out_valid && out_data == FILLW) fill_seen++;
      if (out_valid && out_data != FILLW) pay_seen++;
      if (underflow) under_seen++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [15:0] ts, input logic [7:0] seq, input int len);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_data = {ts, seq, 8'(len)};
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_sop = 1'b0; in_data = {8'h5A, seq, 8'h00, 8'(i)};
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_mode == 0 && dts.size() == 0 && mq.size() == 0 && m_wstate != 1) break;
    end
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog R7 actual=%0d expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 out_valid", out_valid, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 drop_cnt", drop_cnt, 0);
    chk("R1 meas_delay", meas_delay, 0);
    rst = 1'b0;
    // R2, R3, R7: in-order packets
    for (int s = 0; s < 4; s++) send_pkt(m_now, 8'(s), 5);
    send_pkt(m_now, 8'd4, 5);
    // R5, R8: packets 5 and 6 lost -> 2 x 5 fill words
    send_pkt(m_now, 8'd7, 5);
    drain();
    chk("R5 fill words", fill_seen, 10);
    // R6: jump of 13 is beyond MAX_GAP, no fill
    send_pkt(m_now, 8'd20, 5);
    // R3: timestamp ahead of local time wraps to a large age
    send_pkt(m_now + 16'd100, 8'd21, 5);
    drain();
    chk("R6 no extra fill", fill_seen, 10);
    // R9: store overflow and zero length
    cfg_delay = 16'd2000;
    for (int s = 22; s < 26; s++) send_pkt(m_now, 8'(s), 20);
    send_pkt(m_now, 8'd26, 0);
    repeat (10) @(negedge clk);
    chk("R9 drop count", drop_cnt, 2);
    cfg_delay = 16'd30;
    drain();
    chk("R2 payload words", pay_seen, 100);
    chk("R8 all words", pay_seen + fill_seen, 110);
    chk("R10 underflow seen", (under_seen > 0) ? 1 : 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule